// File: doc/BRIEF.md
# Running-Sum Edge Smoothing Filter (one lane)

This block smooths the sixteen samples that straddle a block edge in one pixel lane. The samples run from the outermost sample on the near side, at position 0, to the outermost sample on the far side, at position 15. The edge lies between positions 7 and 8. Two strengths are offered. The wide mode rewrites positions 1 to 14 with a 15-tap window. The medium mode rewrites positions 5 to 10 with a 7-tap window that only draws on positions 4 to 11.

One accumulator produces all outputs, one per cycle. It is loaded with the first window sum. After each output, two departing terms are subtracted and two entering terms are added. A tap that would fall outside the sample range reuses the nearest end sample. Every update reads the captured original samples and never a value already produced. A per-lane enable chooses between the smoothed value and the original sample at each output position.

A block of samples is accepted on a valid/ready handshake. The input is ready only while the block is idle, so a new block waits until the previous one has finished streaming. Results leave on a valid/ready stream tagged with their position, and a final-beat flag marks the last one. The output holds steady while the consumer keeps ready low. A one-cycle done pulse follows the final transfer.

Top module: `lf_wide_smoother`

## Requirements
- R1: After reset, m_valid is 0, s_ready is 1 and done is 0.
- R2: Wide mode (s_wide=1) emits positions 1 through 14 in ascending order, one per transfer, with m_last set only on position 14. Positions 0 and 15 are never emitted.
- R3: In wide mode, the value at position k is (x[k] + Σ x[clamp(j,0,15)] for j=k-7..k+7 + 8) >> 4. Here x[i] is the sample in bits [i*BIT_DEPTH +: BIT_DEPTH] of s_samples.
- R4: Medium mode (s_wide=0) emits positions 5 through 10 in ascending order, with m_last only on position 10. The value at position k is (x[k] + Σ x[clamp(j,4,11)] for j=k-3..k+3 + 4) >> 3.
- R5: When s_en was 0 at acceptance, every emitted value equals the original sample at its position.
- R6: While m_valid is 1 and m_ready is 0, m_data and m_pos hold their values.
- R7: s_ready is 0 while a block is streaming. Outputs depend only on the samples captured at acceptance, whatever s_samples does afterwards.
- R8: done is a single-cycle pulse, high in the cycle right after the final transfer.
- R9: Samples at full scale (2^BIT_DEPTH-1) and sharp full-scale steps give exact results with no wrap-around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Sample block offered |
| s_ready | output | 1 | Block can be accepted (idle) |
| s_samples | input | 16*BIT_DEPTH | Sixteen samples, position i at bits [i*BIT_DEPTH +: BIT_DEPTH] |
| s_wide | input | 1 | 1 selects wide mode, 0 selects medium mode |
| s_en | input | 1 | Lane enable: 1 applies smoothing, 0 passes originals |
| m_valid | output | 1 | Output value available |
| m_ready | input | 1 | Consumer accepts the value |
| m_data | output | BIT_DEPTH | Filtered or original sample |
| m_pos | output | 4 | Position of m_data (0..15) |
| m_last | output | 1 | Final value of the block |
| done | output | 1 | One-cycle pulse after the final transfer |

## Verification
The bench targets the clamped ends of each window: the first outputs next to position 0 (or 4), and the last outputs next to position 15 (or 11). A design that replicated the wrong end sample, or stepped the window one tap off, would be wrong only at those positions. Full-scale blocks and full-scale steps expose an accumulator too narrow or a wrong shift, which would produce wrapped or halved values. Random stalls on the output show whether data changes under back-pressure or a transfer is lost. Disabled blocks and junk driven on s_samples mid-stream reveal any leak of filtered values or of recaptured inputs.

// File: rtl/lf_pkg.sv
package lf_pkg;
  localparam int NPOS = 16;
  localparam int PW   = $clog2(NPOS);
  typedef logic [PW-1:0] pos_t;
endpackage

// File: rtl/lf_seq.sv
module lf_seq
  import lf_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic wide_in,
  input  logic adv,
  output logic busy,
  output logic wide,
  output pos_t pos,
  output logic last,
  output pos_t lo_idx,
  output pos_t hi_idx,
  output pos_t nxt_idx,
  output logic done
);
  localparam int W_R     = 7;
  localparam int W_FIRST = 1;
  localparam int W_LAST  = NPOS - 2;
  localparam int M_R     = 3;
  localparam int M_LO    = NPOS / 2 - 4;
  localparam int M_HI    = NPOS / 2 + 3;
  localparam int M_FIRST = M_LO + 1;
  localparam int M_LAST  = M_HI - 1;

  int k_i, lo_i, hi_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      wide <= 1'b0;
      pos  <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        busy <= 1'b1;
        wide <= wide_in;
        pos  <= wide_in ? pos_t'(W_FIRST) : pos_t'(M_FIRST);
      end else if (adv) begin
        if (last) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          pos <= pos + 1'b1;
        end
      end
    end
  end

  always_comb begin
    k_i = int'(pos);
    if (wide) begin
      lo_i = (k_i - W_R < 0) ? 0 : k_i - W_R;
      hi_i = (k_i + W_R + 1 > NPOS - 1) ? NPOS - 1 : k_i + W_R + 1;
      last = (k_i == W_LAST);
    end else begin
      lo_i = (k_i - M_R < M_LO) ? M_LO : k_i - M_R;
      hi_i = (k_i + M_R + 1 > M_HI) ? M_HI : k_i + M_R + 1;
      last = (k_i == M_LAST);
    end
    lo_idx  = pos_t'(lo_i);
    hi_idx  = pos_t'(hi_i);
    nxt_idx = pos + 1'b1;
  end
endmodule

// File: rtl/lf_acc.sv
module lf_acc #(
  parameter int ACC_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [ACC_W-1:0] init,
  input  logic             adv,
  input  logic [ACC_W-1:0] sub_a,
  input  logic [ACC_W-1:0] sub_b,
  input  logic [ACC_W-1:0] add_a,
  input  logic [ACC_W-1:0] add_b,
  output logic [ACC_W-1:0] acc
);
  always_ff @(posedge clk) begin
    if (!rst_n)    acc <= '0;
    else if (load) acc <= init;
    else if (adv)  acc <= acc - sub_a - sub_b + add_a + add_b;
  end
endmodule

// File: rtl/lf_wide_smoother.sv
module lf_wide_smoother
  import lf_pkg::*;
#(
  parameter int BIT_DEPTH = 10
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      s_valid,
  output logic                      s_ready,
  input  logic [NPOS*BIT_DEPTH-1:0] s_samples,
  input  logic                      s_wide,
  input  logic                      s_en,
  output logic                      m_valid,
  input  logic                      m_ready,
  output logic [BIT_DEPTH-1:0]      m_data,
  output logic [PW-1:0]             m_pos,
  output logic                      m_last,
  output logic                      done
);
  localparam int ACC_W   = BIT_DEPTH + 5;
  localparam int W_SHIFT = 4;
  localparam int M_SHIFT = 3;
  localparam int M_BASE  = NPOS / 2 - 4;

  logic [BIT_DEPTH-1:0] smp [NPOS];
  logic [ACC_W-1:0]     in_w [NPOS];
  logic [ACC_W-1:0]     init_sum, acc, filt;
  logic                 en_q, busy, wide, last, start, adv;
  pos_t                 pos, lo_idx, hi_idx, nxt_idx;

  assign s_ready = !busy;
  assign start   = s_valid && s_ready;
  assign adv     = m_valid && m_ready;

  for (genvar i = 0; i < NPOS; i++) begin : g_smp
    assign in_w[i] = ACC_W'(s_samples[i*BIT_DEPTH +: BIT_DEPTH]);
    always_ff @(posedge clk) begin
      if (!rst_n)     smp[i] <= '0;
      else if (start) smp[i] <= s_samples[i*BIT_DEPTH +: BIT_DEPTH];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     en_q <= 1'b0;
    else if (start) en_q <= s_en;
  end

  // first window sums, edge sample replicated toward the outside
  always_comb begin
    if (s_wide) begin
      init_sum = ACC_W'(7) * in_w[0] + ACC_W'(2) * in_w[1] + ACC_W'(8);
      for (int j = 2; j <= NPOS / 2; j++) init_sum = init_sum + in_w[j];
    end else begin
      init_sum = ACC_W'(3) * in_w[M_BASE] + ACC_W'(2) * in_w[M_BASE+1] + ACC_W'(4);
      for (int j = M_BASE + 2; j <= NPOS / 2; j++) init_sum = init_sum + in_w[j];
    end
  end

  lf_seq u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .wide_in (s_wide),
    .adv     (adv),
    .busy    (busy),
    .wide    (wide),
    .pos     (pos),
    .last    (last),
    .lo_idx  (lo_idx),
    .hi_idx  (hi_idx),
    .nxt_idx (nxt_idx),
    .done    (done)
  );

  lf_acc #(.ACC_W(ACC_W)) u_acc (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (start),
    .init  (init_sum),
    .adv   (adv),
    .sub_a (ACC_W'(smp[lo_idx])),
    .sub_b (ACC_W'(smp[pos])),
    .add_a (ACC_W'(smp[nxt_idx])),
    .add_b (ACC_W'(smp[hi_idx])),
    .acc   (acc)
  );

  assign filt    = wide ? (acc >> W_SHIFT) : (acc >> M_SHIFT);
  assign m_valid = busy;
  assign m_pos   = pos;
  assign m_last  = last;
  assign m_data  = en_q ? filt[BIT_DEPTH-1:0] : smp[pos];
endmodule

// File: rtl/lf_wide_smoother_chk.sv
module lf_wide_smoother_chk #(
  parameter int BIT_DEPTH = 10
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 s_ready,
  input logic                 m_valid,
  input logic                 m_ready,
  input logic [BIT_DEPTH-1:0] m_data,
  input logic [3:0]           m_pos,
  input logic                 m_last,
  input logic                 done
);
  // R6
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |=> m_valid && $stable(m_data) && $stable(m_pos));
  // R7
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> !s_ready);
  // R8
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && m_ready && m_last |=> done);
  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R2
  pos_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && m_ready && !m_last |=> m_valid && (m_pos == 4'($past(m_pos) + 4'd1)));
  // R2
  edge_untouched_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> (m_pos != 4'd0) && (m_pos != 4'd15));
endmodule

bind lf_wide_smoother lf_wide_smoother_chk #(.BIT_DEPTH(BIT_DEPTH)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .s_ready (s_ready),
  .m_valid (m_valid),
  .m_ready (m_ready),
  .m_data  (m_data),
  .m_pos   (m_pos),
  .m_last  (m_last),
  .done    (done)
);

// File: tb/tb_lf_wide_smoother.sv
module tb_lf_wide_smoother;
  localparam int BD = 10;
  localparam int MAXV = (1 << BD) - 1;

  logic clk = 0, rst_n = 0;
  logic s_valid = 0, s_wide = 0, s_en = 0, m_ready = 0;
  logic [16*BD-1:0] s_samples = '0;
  logic s_ready, m_valid, m_last, done;
  logic [BD-1:0] m_data;
  logic [3:0] m_pos;

  int checks = 0, fails = 0, cyc = 0;
  int x [16];

  always #2 clk = ~clk;

  lf_wide_smoother #(.BIT_DEPTH(BD)) dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  function automatic int clampi(int v, int lo, int hi);
    return v < lo ? lo : (v > hi ? hi : v);
  endfunction

  function automatic int ref_val(int k, bit wide, bit en);
    int r = wide ? 7 : 3;
    int lo = wide ? 0 : 4;
    int hi = wide ? 15 : 11;
    int s = x[k] + (wide ? 8 : 4);
    if (!en) return x[k];
    for (int j = k - r; j <= k + r; j++) s += x[clampi(j, lo, hi)];
    return wide ? (s >> 4) : (s >> 3);
  endfunction

  task automatic run(input bit wide, input bit en, input bit stall, input string req);
    int first = wide ? 1 : 5;
    int lastp = wide ? 14 : 10;
    int k = first;
    bit stalled = 0;
    int pd = 0, pp = 0;
    @(negedge clk);
    for (int i = 0; i < 16; i++) s_samples[i*BD +: BD] = BD'(x[i]);
    s_wide = wide; s_en = en; s_valid = 1;
    chk(s_ready == 1, "R7", s_ready, 1);
    @(negedge clk);
    s_valid = 0;
    s_samples = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
    chk(s_ready == 0, "R7", s_ready, 0);
    chk(done == 0, "R8", done, 0);
    while (k <= lastp) begin
      m_ready = stall ? ($urandom % 3 != 0) : 1'b1;
      if (stalled) begin
        chk(m_valid && m_data == BD'(pd) && m_pos == 4'(pp), "R6", m_data, pd);
      end
      if (m_valid && m_ready) begin
        chk(m_pos == 4'(k), wide ? "R2" : "R4", m_pos, k);
        chk(m_data == BD'(ref_val(k, wide, en)), en ? (wide ? "R3" : "R4") : "R5",
            m_data, ref_val(k, wide, en));
        chk(m_last == (k == lastp), wide ? "R2" : "R4", m_last, k == lastp);
        k++;
      end
      stalled = m_valid && !m_ready;
      pd = m_data; pp = m_pos;
      if (req == "R9" && k > lastp) chk(1, "R9", 0, 0);
      @(negedge clk);
    end
    m_ready = 0;
    chk(done == 1 && m_valid == 0, "R8", done, 1);
    @(negedge clk);
    chk(done == 0 && s_ready == 1, "R8", done, 0);
  endtask

  initial begin
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    chk(m_valid == 0 && s_ready == 1 && done == 0, "R1", {m_valid, s_ready, done}, 3'b010);
    rst_n = 1;
    // R9 directed extremes
    for (int i = 0; i < 16; i++) x[i] = MAXV;
    run(1, 1, 0, "R9");
    run(0, 1, 1, "R9");
    for (int i = 0; i < 16; i++) x[i] = (i < 8) ? 0 : MAXV;
    run(1, 1, 1, "R9");
    run(0, 1, 0, "R9");
    for (int i = 0; i < 16; i++) x[i] = (i == 0 || i == 15) ? MAXV : 0;
    run(1, 1, 0, "R3");
    for (int i = 0; i < 16; i++) x[i] = (i == 4 || i == 11) ? MAXV : 0;
    run(0, 1, 0, "R4");
    // random mix: uniform, smooth and stepped blocks
    for (int n = 0; n < 60; n++) begin
      int base = $urandom % (MAXV + 1);
      for (int i = 0; i < 16; i++) begin
        case (n % 3)
          0: x[i] = $urandom % (MAXV + 1);
          1: x[i] = clampi(base + int'($urandom % 9) - 4, 0, MAXV);
          default: x[i] = (i < 8) ? base : clampi(base + int'($urandom % 200) - 100, 0, MAXV);
        endcase
      end
      run(($urandom % 2) == 1, ($urandom % 4) != 0, 1, "R5");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule